// File: doc/BRIEF.md
# Streaming Pixel Calibration and Defect Repair Stage

This block sits in the readout path of a flat panel detector. It takes raw detector samples as a raster-ordered valid/ready stream. For every sample it removes a dark-level offset, scales the result by a flat-field gain coefficient and saturates the value to the 16-bit output range. Samples that the defect map marks as bad are replaced by a value taken from their neighbours: horizontal neighbours first, then the repaired sample directly above.

The three calibration maps (offset, gain, defect flag) live outside the block. They are read through a single address port, and their data returns exactly one clock after the address. A mode input picks how that address is formed: from the column alone, when one correction is shared by a whole column, or from the full pixel position. Frame-start and line-end markers travel alongside each sample. A stall at the output holds the whole pipeline without losing or repeating any sample.

Top module: `pixel_corrector`

## Requirements
- R1: For a good pixel, the output is floor((pixel - offset) * gain / 16384), taken with the map entries addressed for that pixel.
- R2: Gain is unsigned with 14 fraction bits, so a gain of 16384 combined with an offset of 0 returns the input unchanged.
- R3: When the pixel is less than or equal to its offset, the output is 0.
- R4: When the scaled result exceeds 65535, the output is 65535.
- R5: With `map_per_pixel`=1, `map_addr` = row*COLS + column. With `map_per_pixel`=0, `map_addr` = column. Map data is used one clock after its address. Row and column restart at 0 on a frame-start sample, and the row advances after each line-end sample.
- R6: A bad pixel whose left and right neighbours in the same row are both good outputs floor((left + right) / 2) of their corrected values.
- R7: A bad pixel with only one usable horizontal neighbour outputs that neighbour's corrected value. A neighbour is unusable when it is bad or lies outside the row (column 0 has no left neighbour, and a line-end sample has no right neighbour).
- R8: A bad pixel with no usable horizontal neighbour outputs the final output value of the same column in the previous row. In row 0 it outputs its own corrected value.
- R9: Output samples leave in input order. `out_sof` and `out_eol` are set exactly on the samples that carried `in_sof` and `in_eol`.
- R10: While `out_valid`=1 and `out_ready`=0, the output sample and its markers stay unchanged. Under any pattern of stalls and input gaps, every input sample appears exactly once at the output.
- R11: After reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_per_pixel | input | 1 | 1: maps indexed per pixel, 0: per column |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_pixel | input | PIX_W | Raw sample |
| in_sof | input | 1 | Sample is the first of a frame |
| in_eol | input | 1 | Sample is the last of a row |
| map_addr | output | ADDR_W | Read address into all three maps |
| map_offset | input | PIX_W | Dark offset read for the previous address |
| map_gain | input | GAIN_W | Gain coefficient read for the previous address |
| map_bad | input | 1 | Defect flag read for the previous address |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_pixel | output | PIX_W | Corrected sample |
| out_sof | output | 1 | Frame-start marker, aligned to the output |
| out_eol | output | 1 | Line-end marker, aligned to the output |

## Verification
A stale map address, or a row/column counter that drifts, pairs a sample with another pixel's calibration. The bench gives every map entry a distinct value, so the very first sample that is affected shows a wrong value. A fault in the repair window, such as taking the right neighbour from the wrong sample or keeping a stale previous-row entry, shows only on bad pixels. It shows within the same row for horizontal repair and one row later for vertical fallback, so defect patterns are placed at row edges, in adjacent pairs and in runs of three. Loss of stall control shows up as a missing, repeated or changed sample while `out_ready` is low. This is checked under random stalls combined with random input gaps.

// File: rtl/pc_pkg.sv
package pc_pkg;

   // Source chosen for the value of a sample leaving the repair stage
   typedef enum logic [2:0] {
      SRC_OWN   = 3'd0,
      SRC_AVG   = 3'd1,
      SRC_LEFT  = 3'd2,
      SRC_RIGHT = 3'd3,
      SRC_ABOVE = 3'd4
   } repl_src_e;

endpackage

// File: rtl/pc_addr_gen.sv
module pc_addr_gen #(
   parameter int COLS   = 16,
   parameter int ROWS   = 16,
   parameter int COL_W  = 4,
   parameter int ROW_W  = 4,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              in_sof,
   input  logic              in_eol,
   input  logic              per_pixel,
   output logic [COL_W-1:0]  col_o,
   output logic [ROW_W-1:0]  row_o,
   output logic [ADDR_W-1:0] addr_o
);

   logic [COL_W-1:0] col_q;
   logic [ROW_W-1:0] row_q;

   // a frame-start sample always sits at the origin
   assign col_o = in_sof ? '0 : col_q;
   assign row_o = in_sof ? '0 : row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q <= '0;
         row_q <= '0;
      end else if (accept) begin
         if (in_eol) begin
            col_q <= '0;
            row_q <= row_o + ROW_W'(1);
         end else begin
            col_q <= col_o + COL_W'(1);
            row_q <= row_o;
         end
      end
   end

   logic [ADDR_W-1:0] pix_addr;
   assign pix_addr = ADDR_W'(row_o) * ADDR_W'(COLS) + ADDR_W'(col_o);
   assign addr_o   = per_pixel ? pix_addr : ADDR_W'(col_o);

   // R5: the column restarts after a line end
   a_r5_col_restart: assert property (@(posedge clk) disable iff (!rst_n)
      accept && in_eol && !in_sof |=> col_q == '0);

endmodule

// File: rtl/pc_calib_alu.sv
module pc_calib_alu #(
   parameter int PIX_W     = 16,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 14
) (
   input  logic [PIX_W-1:0]  pix,
   input  logic [PIX_W-1:0]  offset,
   input  logic [GAIN_W-1:0] gain,
   output logic [PIX_W-1:0]  result
);

   localparam int PROD_W = PIX_W + GAIN_W;

   logic [PIX_W:0]    diff;
   logic              below;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] scaled;
   logic              over;

   assign diff   = {1'b0, pix} - {1'b0, offset};
   assign below  = diff[PIX_W];
   assign prod   = PROD_W'(diff[PIX_W-1:0]) * PROD_W'(gain);
   assign scaled = prod >> GAIN_FRAC;
   assign over   = |scaled[PROD_W-1:PIX_W];

   always_comb begin
      if (below)     result = '0;
      else if (over) result = '1;
      else           result = scaled[PIX_W-1:0];
   end

endmodule

// File: rtl/pc_defect_fix.sv
module pc_defect_fix
   import pc_pkg::*;
#(
   parameter int PIX_W     = 16,
   parameter int COLS      = 16,
   parameter int COL_W     = 4,
   parameter int ROUND_AVG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             b_v,
   input  logic [PIX_W-1:0] b_corr,
   input  logic             b_bad,
   input  logic             b_sof,
   input  logic             b_eol,
   input  logic [COL_W-1:0] b_col,
   input  logic             b_row0,
   output logic             take_b,
   input  logic             out_ready,
   output logic             out_valid,
   output logic [PIX_W-1:0] out_pixel,
   output logic             out_sof,
   output logic             out_eol
);

   // centre of the repair window
   logic             c_v, c_bad, c_sof, c_eol, c_row0;
   logic [PIX_W-1:0] c_corr;
   logic [COL_W-1:0] c_col;
   // corrected sample that preceded the centre
   logic [PIX_W-1:0] l_val;
   logic             l_bad;
   // output register
   logic             o_v, o_sof, o_eol;
   logic [PIX_W-1:0] o_pix;
   // final values of the previous row
   logic [PIX_W-1:0] lb_q [COLS];

   logic o_free, c_fire;
   assign o_free = !o_v || out_ready;
   // a mid-row centre waits until its right neighbour is present
   assign c_fire = c_v && o_free && (c_eol || b_v);
   assign take_b = b_v && (!c_v || c_fire);

   always_ff @(posedge clk) begin
      if (!rst_n)      c_v <= 1'b0;
      else if (take_b) c_v <= 1'b1;
      else if (c_fire) c_v <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (take_b) begin
         c_corr <= b_corr;
         c_bad  <= b_bad;
         c_sof  <= b_sof;
         c_eol  <= b_eol;
         c_col  <= b_col;
         c_row0 <= b_row0;
      end
   end

   // neighbour selection
   logic             rnd;
   logic [PIX_W:0]   nb_sum;
   logic [PIX_W-1:0] nb_avg, above, fix_val, nb_lo, nb_hi;
   logic             left_ok, right_ok;
   repl_src_e        src;

   if (ROUND_AVG != 0) begin : g_avg_round
      assign rnd = 1'b1;
   end else begin : g_avg_floor
      assign rnd = 1'b0;
   end

   assign nb_sum   = {1'b0, l_val} + {1'b0, b_corr} + (PIX_W+1)'(rnd);
   assign nb_avg   = PIX_W'(nb_sum >> 1);
   assign left_ok  = (c_col != '0) && !l_bad;
   assign right_ok = !c_eol && !b_bad;
   assign above    = lb_q[c_col];
   assign nb_lo    = (l_val < b_corr) ? l_val : b_corr;
   assign nb_hi    = (l_val < b_corr) ? b_corr : l_val;

   always_comb begin
      if (!c_bad)                src = SRC_OWN;
      else if (left_ok && right_ok) src = SRC_AVG;
      else if (left_ok)          src = SRC_LEFT;
      else if (right_ok)         src = SRC_RIGHT;
      else if (!c_row0)          src = SRC_ABOVE;
      else                       src = SRC_OWN;
   end

   always_comb begin
      case (src)
         SRC_AVG:   fix_val = nb_avg;
         SRC_LEFT:  fix_val = l_val;
         SRC_RIGHT: fix_val = b_corr;
         SRC_ABOVE: fix_val = above;
         default:   fix_val = c_corr;
      endcase
   end

   always_ff @(posedge clk) begin
      if (c_fire) begin
         l_val        <= c_corr;
         l_bad        <= c_bad;
         lb_q[c_col]  <= fix_val;
         o_pix        <= fix_val;
         o_sof        <= c_sof;
         o_eol        <= c_eol;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         o_v <= 1'b0;
      else if (c_fire)    o_v <= 1'b1;
      else if (out_ready) o_v <= 1'b0;
   end

   assign out_valid = o_v;
   assign out_pixel = o_pix;
   assign out_sof   = o_sof;
   assign out_eol   = o_eol;

   // R1: a good sample leaves with its own corrected value
   a_r1_good_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
      c_fire && !c_bad |=> out_pixel == $past(c_corr));

   // R6: an average of two neighbours lies between them
   a_r6_avg_between: assert property (@(posedge clk) disable iff (!rst_n)
      c_fire && c_bad && left_ok && right_ok |=>
         out_pixel >= $past(nb_lo) && out_pixel <= $past(nb_hi));

   // R9: a mid-row sample never leaves before its right neighbour arrives
   a_r9_wait_right: assert property (@(posedge clk) disable iff (!rst_n)
      c_v && !c_eol && !b_v |=> !$rose(out_valid) || $past(!c_v));

endmodule

// File: rtl/pixel_corrector.sv
module pixel_corrector #(
   parameter int PIX_W     = 16,
   parameter int GAIN_W    = 16,
   parameter int GAIN_FRAC = 14,
   parameter int COLS      = 16,
   parameter int ROWS      = 16,
   parameter int ROUND_AVG = 0,
   localparam int COL_W    = $clog2(COLS),
   localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int ADDR_W   = $clog2(COLS * ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              map_per_pixel,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PIX_W-1:0]  in_pixel,
   input  logic              in_sof,
   input  logic              in_eol,
   output logic [ADDR_W-1:0] map_addr,
   input  logic [PIX_W-1:0]  map_offset,
   input  logic [GAIN_W-1:0] map_gain,
   input  logic              map_bad,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [PIX_W-1:0]  out_pixel,
   output logic              out_sof,
   output logic              out_eol
);

   if (COLS < 2) begin : g_bad_cols
      $error("pixel_corrector: COLS must be at least 2");
   end
   if (GAIN_FRAC >= GAIN_W) begin : g_bad_gain
      $error("pixel_corrector: gain needs at least one integer bit");
   end
   if (PIX_W < 2) begin : g_bad_pix
      $error("pixel_corrector: PIX_W too small");
   end

   logic              accept, a_move, take_b;
   logic [COL_W-1:0]  ag_col;
   logic [ROW_W-1:0]  ag_row;
   logic [ADDR_W-1:0] ag_addr;

   // stage A: sample waiting for its map read
   logic              a_v, a_sof, a_eol, a_row0;
   logic [PIX_W-1:0]  a_pix;
   logic [COL_W-1:0]  a_col;
   logic [ADDR_W-1:0] a_addr;
   // stage B: corrected sample
   logic              b_v, b_bad, b_sof, b_eol, b_row0;
   logic [PIX_W-1:0]  b_corr;
   logic [COL_W-1:0]  b_col;
   logic [PIX_W-1:0]  alu_res;

   assign a_move   = a_v && (!b_v || take_b);
   assign in_ready = !a_v || a_move;
   assign accept   = in_valid && in_ready;
   // held address keeps the map output aligned with stage A during stalls
   assign map_addr = accept ? ag_addr : a_addr;

   pc_addr_gen #(
      .COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W)
   ) addr_i (
      .clk(clk), .rst_n(rst_n), .accept(accept), .in_sof(in_sof),
      .in_eol(in_eol), .per_pixel(map_per_pixel),
      .col_o(ag_col), .row_o(ag_row), .addr_o(ag_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      a_v <= 1'b0;
      else if (accept) a_v <= 1'b1;
      else if (a_move) a_v <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         a_pix  <= in_pixel;
         a_sof  <= in_sof;
         a_eol  <= in_eol;
         a_col  <= ag_col;
         a_row0 <= (ag_row == '0);
         a_addr <= ag_addr;
      end
   end

   pc_calib_alu #(
      .PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)
   ) alu_i (
      .pix(a_pix), .offset(map_offset), .gain(map_gain), .result(alu_res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      b_v <= 1'b0;
      else if (a_move) b_v <= 1'b1;
      else if (take_b) b_v <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (a_move) begin
         b_corr <= alu_res;
         b_bad  <= map_bad;
         b_sof  <= a_sof;
         b_eol  <= a_eol;
         b_col  <= a_col;
         b_row0 <= a_row0;
      end
   end

   pc_defect_fix #(
      .PIX_W(PIX_W), .COLS(COLS), .COL_W(COL_W), .ROUND_AVG(ROUND_AVG)
   ) fix_i (
      .clk(clk), .rst_n(rst_n), .b_v(b_v), .b_corr(b_corr), .b_bad(b_bad),
      .b_sof(b_sof), .b_eol(b_eol), .b_col(b_col), .b_row0(b_row0),
      .take_b(take_b), .out_ready(out_ready), .out_valid(out_valid),
      .out_pixel(out_pixel), .out_sof(out_sof), .out_eol(out_eol)
   );

   // R10: a stalled output does not move
   a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=>
         out_valid && $stable(out_pixel) && $stable(out_sof) && $stable(out_eol));

   // R3: a sample at or below its offset becomes zero
   a_r3_low_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      a_move && (a_pix <= map_offset) |=> b_corr == '0);

   // R5: while stage A waits, the map keeps seeing its address
   a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      a_v && !in_ready |=> in_ready || $stable(map_addr));

   // R11: nothing is offered on the first cycle after reset
   a_r11_idle_after_reset: assert property (@(posedge clk)
      $past(!rst_n) |-> !out_valid);

endmodule

// File: tb/pixel_corrector_tb.sv
`timescale 1ns/1ps
module pixel_corrector_tb_top;

   localparam int COLS = 8;
   localparam int ROWS = 4;
   localparam int NPIX = COLS * ROWS;
   localparam int AW   = $clog2(NPIX);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          map_per_pixel = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [15:0]   in_pixel = '0;
   logic          in_sof = 1'b0;
   logic          in_eol = 1'b0;
   logic [AW-1:0] map_addr;
   logic [15:0]   map_offset;
   logic [15:0]   map_gain;
   logic          map_bad;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [15:0]   out_pixel;
   logic          out_sof;
   logic          out_eol;

   always #10 clk = ~clk;

   pixel_corrector #(.COLS(COLS), .ROWS(ROWS)) dut_i (
      .clk(clk), .rst_n(rst_n), .map_per_pixel(map_per_pixel),
      .in_valid(in_valid), .in_ready(in_ready), .in_pixel(in_pixel),
      .in_sof(in_sof), .in_eol(in_eol), .map_addr(map_addr),
      .map_offset(map_offset), .map_gain(map_gain), .map_bad(map_bad),
      .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
      .out_sof(out_sof), .out_eol(out_eol)
   );

   int pix_in [NPIX];
   int off_m  [NPIX];
   int gain_m [NPIX];
   int bad_m  [NPIX];
   int exp_px [NPIX];

   // map memories with one clock of read latency
   always @(posedge clk) begin
      map_offset <= 16'(off_m[map_addr]);
      map_gain   <= 16'(gain_m[map_addr]);
      map_bad    <= (bad_m[map_addr] != 0);
   end

   int n_run = 0;
   int n_fail = 0;

   task automatic check(input string req, input int act, input int exp_v);
      n_run++;
      if (act != exp_v) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   function automatic int midx(int r, int c);
      return map_per_pixel ? r * COLS + c : c;
   endfunction

   function automatic int corr_of(int i);
      longint d, p;
      int m;
      m = midx(i / COLS, i % COLS);
      d = longint'(pix_in[i]) - longint'(off_m[m]);
      if (d <= 0) return 0;
      p = (d * longint'(gain_m[m])) >>> 14;
      if (p > 65535) return 65535;
      return int'(p);
   endfunction

   function automatic void build_expected();
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) begin
            int i;
            bit lok, rok;
            i = r * COLS + c;
            if (bad_m[midx(r, c)] == 0) exp_px[i] = corr_of(i);
            else begin
               lok = (c > 0) && (bad_m[midx(r, c - 1)] == 0);
               rok = (c < COLS - 1) && (bad_m[midx(r, c + 1)] == 0);
               if (lok && rok)  exp_px[i] = (corr_of(i - 1) + corr_of(i + 1)) / 2;
               else if (lok)    exp_px[i] = corr_of(i - 1);
               else if (rok)    exp_px[i] = corr_of(i + 1);
               else if (r > 0)  exp_px[i] = exp_px[i - COLS];
               else             exp_px[i] = corr_of(i);
            end
         end
      end
   endfunction

   // streams one frame, compares every output, and checks stall behaviour
   task automatic run_frame(input string req, input int ready_pct, input int gap_pct);
      int ii = 0, oi = 0, cyc = 0;
      bit stalled = 0;
      int held_px = 0;
      build_expected();
      while (oi < NPIX && cyc < 4000) begin
         bit hin, hout;
         @(negedge clk);
         if (stalled) begin
            check("R10 hold valid", int'(out_valid), 1);
            check("R10 hold pixel", int'(out_pixel), held_px);
         end
         in_valid  = (ii < NPIX) && ($urandom_range(99) >= gap_pct);
         in_pixel  = 16'(pix_in[ii < NPIX ? ii : 0]);
         in_sof    = (ii == 0);
         in_eol    = (ii % COLS == COLS - 1);
         out_ready = ($urandom_range(99) < ready_pct);
         #1;
         hin  = in_valid && in_ready;
         hout = out_valid && out_ready;
         stalled = out_valid && !out_ready;
         held_px = int'(out_pixel);
         if (hout) begin
            check(req, int'(out_pixel), exp_px[oi]);
            check("R9 sof", int'(out_sof), int'(oi == 0));
            check("R9 eol", int'(out_eol), int'(oi % COLS == COLS - 1));
            oi++;
         end
         if (hin) ii++;
         cyc++;
      end
      check("R10 all samples delivered", oi, NPIX);
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b1;
      repeat (3) @(negedge clk);
      check("R10 no extra output", int'(out_valid), 0);
   endtask

   task automatic clear_maps(input int gain);
      for (int i = 0; i < NPIX; i++) begin
         off_m[i] = 0; gain_m[i] = gain; bad_m[i] = 0;
         pix_in[i] = $urandom_range(65535);
      end
   endtask

   task automatic t_reset();
      #1;
      check("R11 out_valid", int'(out_valid), 0);
      check("R11 in_ready", int'(in_ready), 1);
   endtask

   task automatic t_identity();
      map_per_pixel = 1'b1;
      clear_maps(16384);
      run_frame("R2 unity gain", 100, 0);
   endtask

   task automatic t_arith();
      map_per_pixel = 1'b1;
      for (int i = 0; i < NPIX; i++) begin
         off_m[i]  = $urandom_range(4000);
         gain_m[i] = $urandom_range(10000, 24000);
         bad_m[i]  = 0;
         pix_in[i] = $urandom_range(4500, 40000);
      end
      run_frame("R1 offset and gain", 100, 0);
   endtask

   task automatic t_low_clamp();
      map_per_pixel = 1'b1;
      for (int i = 0; i < NPIX; i++) begin
         off_m[i]  = 30000 + i;
         gain_m[i] = 65535;
         bad_m[i]  = 0;
         pix_in[i] = (i % 2 == 0) ? 30000 + i : $urandom_range(29000);
      end
      run_frame("R3 low clamp", 100, 0);
   endtask

   task automatic t_high_clamp();
      map_per_pixel = 1'b1;
      for (int i = 0; i < NPIX; i++) begin
         off_m[i]  = i;
         gain_m[i] = (i % 3 == 0) ? 65535 : 32768 + 1;
         bad_m[i]  = 0;
         pix_in[i] = 40000 + i * 700;
      end
      run_frame("R4 high clamp", 100, 0);
   endtask

   task automatic t_column_mode();
      map_per_pixel = 1'b0;
      for (int i = 0; i < NPIX; i++) begin
         off_m[i]  = (i < COLS) ? 100 * i : 60000;
         gain_m[i] = (i < COLS) ? 12000 + 800 * i : 3;
         bad_m[i]  = 0;
         pix_in[i] = $urandom_range(2000, 50000);
      end
      run_frame("R5 column indexed maps", 100, 0);
      map_per_pixel = 1'b1;
   endtask

   task automatic t_defect_avg();
      map_per_pixel = 1'b1;
      clear_maps(16384);
      bad_m[0 * COLS + 2] = 1;
      bad_m[1 * COLS + 5] = 1;
      bad_m[2 * COLS + 3] = 1;
      bad_m[3 * COLS + 6] = 1;
      run_frame("R6 neighbour average", 100, 0);
   endtask

   task automatic t_defect_edge();
      map_per_pixel = 1'b1;
      clear_maps(16384);
      bad_m[0 * COLS + 0] = 1;
      bad_m[1 * COLS + COLS - 1] = 1;
      bad_m[2 * COLS + 3] = 1;
      bad_m[2 * COLS + 4] = 1;
      bad_m[3 * COLS + 1] = 1;
      bad_m[3 * COLS + 0] = 0;
      bad_m[3 * COLS + 2] = 1;
      run_frame("R7 single neighbour", 100, 0);
   endtask

   task automatic t_defect_vertical();
      map_per_pixel = 1'b1;
      clear_maps(16384);
      for (int c = 2; c <= 4; c++) bad_m[0 * COLS + c] = 1;
      for (int c = 2; c <= 4; c++) bad_m[2 * COLS + c] = 1;
      bad_m[1 * COLS + 0] = 1;
      bad_m[1 * COLS + 1] = 1;
      bad_m[3 * COLS + COLS - 1] = 1;
      bad_m[3 * COLS + COLS - 2] = 1;
      run_frame("R8 previous row fallback", 100, 0);
   endtask

   task automatic t_backpressure();
      map_per_pixel = 1'b1;
      for (int f = 0; f < 3; f++) begin
         for (int i = 0; i < NPIX; i++) begin
            off_m[i]  = $urandom_range(3000);
            gain_m[i] = $urandom_range(8000, 30000);
            bad_m[i]  = ($urandom_range(99) < 25) ? 1 : 0;
            pix_in[i] = $urandom_range(65535);
         end
         run_frame("R10 stalls and gaps", 40, 30);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_identity();
      t_arith();
      t_low_clamp();
      t_high_clamp();
      t_column_mode();
      t_defect_avg();
      t_defect_edge();
      t_defect_vertical();
      t_backpressure();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule